// File: doc/BRIEF.md
# Hardware Event Counter Bank

This block holds a bank of general-purpose 64-bit performance counters for a small processor core. The core presents a vector of single-cycle event pulses every clock. Each counter has its own event-selector register. A counter advances by one in any cycle where at least one of its selected events fired. Several selected events firing together still advance it by only one. The event vector and the per-counter trigger are each held in a register. An event seen at one clock edge therefore changes the counter value two edges later.

Software reaches the bank through a small register port with a write strobe, a 12-bit address and 32-bit data. The read data is combinational. Selectors, the low and high halves of each counter, and a mask register that grants user-mode read access to each counter all have their own addresses. The access mask is also driven out as a vector for the core's privilege check. Selector bit 1 is reserved and always reads back as 0, so event line 1 can never advance a counter.

Top module: `hpc_bank`

## Requirements
- R1: After a synchronous active-high reset, every selector, both halves of every counter and the user-access mask read 0, and `user_rd_ok` is 0.
- R2: An event pulse at clock edge E makes the counter change value at edge E+2. The new value is visible on `csr_rdata` after E+2 and not after E+1.
- R3: In a cycle where one or more of a counter's selected events fired, the counter advances by exactly 1. With no selected event firing, it holds. A selector of 0 never counts.
- R4: For counter i (0 <= i < NUM_CTR), the registers sit at these addresses: the selector at 0x320 + i + 3, the low half at 0xB00 + i + 3, and the high half at 0xB80 + i + 3. Selectors read back zero-extended.
- R5: On a selector write, bit 1 is stored as 0 whatever value is written. A pulse on event line 1 alone therefore never advances any counter.
- R6: The user-access mask is at 0x306. Bit i+3 belongs to counter i and is read/write. Bit i of `user_rd_ok` equals the stored bit.
- R7: Each counter is 64 bits wide. When the low half is 0xFFFFFFFF and the counter advances, the low half wraps to 0 and the high half rises by 1 at the same edge.
- R8: A write to either half of a counter takes priority over an increment at the same edge. The written half takes the data, the other half is left unchanged, and no increment happens at that edge.
- R9: A read at any selector or counter address whose low five bits are below 3, or at or above NUM_CTR+3, returns 0. A write there changes no implemented register.
- R10: Counters advance independently. An event that a counter has not selected leaves that counter unchanged, even while other counters advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | EVT_W | Event pulses from the core, one bit per event line |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register address, used for both read and write |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| user_rd_ok | output | max(NUM_CTR,1) | Per-counter user-mode read permission |

## Verification
The bench builds the bank with NUM_CTR=5 and EVT_W=8. With five counters, the indices from 5 to 28 fall outside the bank, so the zero-read and write-ignore paths can be exercised inside the normal address pages. An 8-bit event vector is narrow enough to give each counter a different selector and to drive single, multiple, reserved and unselected event lines against them. Counter halves are preloaded near the 32-bit boundary so that the carry into the high half and write-over-increment collisions happen within a few cycles.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int CSR_AW       = 12;
    localparam int CSR_DW       = 32;
    localparam int IDX_OFS      = 3;   // counter i sits at low index i+3
    localparam int SEL_TIME_BIT = 1;   // reserved selector bit, always 0

    localparam logic [6:0]        PAGE_SEL = 7'h19;  // 0x320..0x33F
    localparam logic [6:0]        PAGE_LO  = 7'h58;  // 0xB00..0xB1F
    localparam logic [6:0]        PAGE_HI  = 7'h5C;  // 0xB80..0xB9F
    localparam logic [CSR_AW-1:0] UEN_ADDR = 12'h306;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SEL,
        RG_LO,
        RG_HI,
        RG_UEN
    } csr_region_e;

    typedef struct packed {
        logic              we_lo;
        logic              we_hi;
        logic [CSR_DW-1:0] data;
    } ctr_wr_t;

    function automatic csr_region_e region_of(input logic [CSR_AW-1:0] a);
        csr_region_e r;
        r = RG_NONE;
        if (a == UEN_ADDR) begin
            r = RG_UEN;
        end else begin
            case (a[CSR_AW-1:5])
                PAGE_SEL: r = RG_SEL;
                PAGE_LO:  r = RG_LO;
                PAGE_HI:  r = RG_HI;
                default:  r = RG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/hpc_evt_qual.sv
module hpc_evt_qual
    import hpc_pkg::*;
#(
    parameter int NUM   = 29,
    parameter int SLOTS = 29,
    parameter int EVT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [EVT_W-1:0]            evt_i,
    input  logic [SLOTS-1:0][EVT_W-1:0] sel_i,
    output logic [SLOTS-1:0]            trig_o
);

    logic [EVT_W-1:0] evt_q;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_i;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_trig
        if (g < NUM) begin : g_on
            logic hit_q;
            always_ff @(posedge clk) begin
                if (rst) hit_q <= 1'b0;
                else     hit_q <= |(evt_q & sel_i[g]);
            end
            assign trig_o[g] = hit_q;
        end else begin : g_off
            assign trig_o[g] = 1'b0;
        end
    end

    // R2
    idle_no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_q == '0) |=> (trig_o == '0));

endmodule

// File: rtl/hpc_counter.sv
module hpc_counter
    import hpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  ctr_wr_t           wr_i,
    output logic [CSR_DW-1:0] lo_o,
    output logic [CSR_DW-1:0] hi_o
);

    logic [2*CSR_DW-1:0] val_q;
    logic                any_wr;

    assign any_wr = wr_i.we_lo | wr_i.we_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (wr_i.we_lo) begin
            val_q[CSR_DW-1:0] <= wr_i.data;
        end else if (wr_i.we_hi) begin
            val_q[2*CSR_DW-1:CSR_DW] <= wr_i.data;
        end else if (trig_i) begin
            val_q <= val_q + 1'b1;
        end
    end

    assign lo_o = val_q[CSR_DW-1:0];
    assign hi_o = val_q[2*CSR_DW-1:CSR_DW];

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lo_o == '0 && hi_o == '0));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !any_wr) |=> ({hi_o, lo_o} == $past({hi_o, lo_o}) + 64'd1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && !any_wr) |=> ($stable(lo_o) && $stable(hi_o)));

    // R7
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !any_wr && lo_o == '1) |=> (lo_o == '0 && hi_o == $past(hi_o) + 1'b1));

    // R8
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i.we_lo |=> (lo_o == $past(wr_i.data) && $stable(hi_o)));

endmodule

// File: rtl/hpc_regs.sv
module hpc_regs
    import hpc_pkg::*;
#(
    parameter int NUM   = 29,
    parameter int SLOTS = 29,
    parameter int EVT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we_i,
    input  logic [CSR_AW-1:0]            addr_i,
    input  logic [CSR_DW-1:0]            wdata_i,
    input  logic [SLOTS-1:0][CSR_DW-1:0] lo_i,
    input  logic [SLOTS-1:0][CSR_DW-1:0] hi_i,
    output logic [SLOTS-1:0][EVT_W-1:0]  sel_o,
    output logic [SLOTS-1:0]             uen_o,
    output ctr_wr_t [SLOTS-1:0]          wr_o,
    output logic [CSR_DW-1:0]            rdata_o
);

    localparam logic [EVT_W-1:0] SEL_KEEP = ~(EVT_W'(1) << SEL_TIME_BIT);

    csr_region_e rg;
    logic [4:0]  idx;
    logic [SLOTS-1:0][EVT_W-1:0] sel_q;
    logic [SLOTS-1:0]            uen_q;

    assign rg  = region_of(addr_i);
    assign idx = addr_i[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            uen_q <= '0;
        end else if (we_i) begin
            for (int i = 0; i < NUM; i++) begin
                if (rg == RG_SEL && idx == 5'(i + IDX_OFS))
                    sel_q[i] <= wdata_i[EVT_W-1:0] & SEL_KEEP;
                if (rg == RG_UEN)
                    uen_q[i] <= wdata_i[i + IDX_OFS];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            wr_o[i].data  = wdata_i;
            wr_o[i].we_lo = we_i && (i < NUM) && rg == RG_LO && idx == 5'(i + IDX_OFS);
            wr_o[i].we_hi = we_i && (i < NUM) && rg == RG_HI && idx == 5'(i + IDX_OFS);
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rg == RG_UEN)
                rdata_o[i + IDX_OFS] = uen_q[i];
            if (idx == 5'(i + IDX_OFS)) begin
                case (rg)
                    RG_SEL:  rdata_o = CSR_DW'(sel_q[i]);
                    RG_LO:   rdata_o = lo_i[i];
                    RG_HI:   rdata_o = hi_i[i];
                    default: ;
                endcase
            end
        end
    end

    assign sel_o = sel_q;
    assign uen_o = uen_q;

    logic idx_ok;
    assign idx_ok = (int'(idx) >= IDX_OFS) && (int'(idx) < NUM + IDX_OFS);

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((rg == RG_SEL || rg == RG_LO || rg == RG_HI) && !idx_ok) |-> (rdata_o == '0));

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        // R5
        sel_time_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && rg == RG_SEL && idx == 5'(g + IDX_OFS)) |=>
            (sel_o[g][SEL_TIME_BIT] == 1'b0 && sel_o[g][0] == $past(wdata_i[0])));

        // R6
        uen_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && rg == RG_UEN) |=> (uen_o[g] == $past(wdata_i[g + IDX_OFS])));
    end

endmodule

// File: rtl/hpc_bank.sv
module hpc_bank
    import hpc_pkg::*;
#(
    parameter int NUM_CTR = 29,
    parameter int EVT_W   = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [EVT_W-1:0]                      evt_i,
    input  logic                                  csr_we,
    input  logic [CSR_AW-1:0]                     csr_addr,
    input  logic [CSR_DW-1:0]                     csr_wdata,
    output logic [CSR_DW-1:0]                     csr_rdata,
    output logic [(NUM_CTR > 0 ? NUM_CTR : 1)-1:0] user_rd_ok
);

    localparam int SLOTS = (NUM_CTR > 0) ? NUM_CTR : 1;

    logic [SLOTS-1:0][EVT_W-1:0]  sel;
    logic [SLOTS-1:0]             trig;
    logic [SLOTS-1:0][CSR_DW-1:0] lo_v;
    logic [SLOTS-1:0][CSR_DW-1:0] hi_v;
    ctr_wr_t [SLOTS-1:0]          wr;

    hpc_regs #(.NUM(NUM_CTR), .SLOTS(SLOTS), .EVT_W(EVT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (csr_we),
        .addr_i  (csr_addr),
        .wdata_i (csr_wdata),
        .lo_i    (lo_v),
        .hi_i    (hi_v),
        .sel_o   (sel),
        .uen_o   (user_rd_ok),
        .wr_o    (wr),
        .rdata_o (csr_rdata)
    );

    hpc_evt_qual #(.NUM(NUM_CTR), .SLOTS(SLOTS), .EVT_W(EVT_W)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .sel_i  (sel),
        .trig_o (trig)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_ctr
        if (g < NUM_CTR) begin : g_on
            hpc_counter u_ctr (
                .clk    (clk),
                .rst    (rst),
                .trig_i (trig[g]),
                .wr_i   (wr[g]),
                .lo_o   (lo_v[g]),
                .hi_o   (hi_v[g])
            );
        end else begin : g_off
            assign lo_v[g] = '0;
            assign hi_v[g] = '0;
        end
    end

endmodule

// File: tb/test_hpc_bank.sv
`timescale 1ns/1ps
module test_hpc_bank;

    localparam int N  = 5;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [EW-1:0] evt_i = '0;
    logic          csr_we = 1'b0;
    logic [11:0]   csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic [N-1:0]  user_rd_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hpc_bank #(.NUM_CTR(N), .EVT_W(EW)) i_hpc_bank (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_i),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .user_rd_ok (user_rd_ok)
    );

    // behavioural reference: state after each edge
    logic [EW-1:0] m_sel [N];
    logic [63:0]   m_cnt [N];
    logic [N-1:0]  m_en;
    logic [EW-1:0] m_evt_hist [$];
    logic [N-1:0]  m_trig;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_sel[i] = '0;
                m_cnt[i] = '0;
            end
            m_en = '0;
            m_trig = '0;
            m_evt_hist = {};
            m_evt_hist.push_back('0);
        end else begin
            logic [EW-1:0] seen;
            logic [N-1:0]  nxt_trig;
            seen = m_evt_hist.pop_front();
            for (int i = 0; i < N; i++) nxt_trig[i] = (seen & m_sel[i]) != 0;
            for (int i = 0; i < N; i++) begin
                if (csr_we && csr_addr == 12'hB00 + 12'(i + 3))
                    m_cnt[i][31:0] = csr_wdata;
                else if (csr_we && csr_addr == 12'hB80 + 12'(i + 3))
                    m_cnt[i][63:32] = csr_wdata;
                else if (m_trig[i])
                    m_cnt[i] = m_cnt[i] + 64'd1;
                if (csr_we && csr_addr == 12'h320 + 12'(i + 3))
                    m_sel[i] = csr_wdata[EW-1:0] & 8'hFD;
                if (csr_we && csr_addr == 12'h306)
                    m_en[i] = csr_wdata[i + 3];
            end
            m_trig = nxt_trig;
            m_evt_hist.push_back(evt_i);
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int k;
        if (a == 12'h306) return 32'(m_en) << 3;
        k = int'(a[4:0]) - 3;
        if (k < 0 || k >= N) return '0;
        case (a[11:5])
            7'h19:   return 32'(m_sel[k]);
            7'h58:   return m_cnt[k][31:0];
            7'h5C:   return m_cnt[k][63:32];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(64'(csr_rdata), 64'(model_read(csr_addr)), "R4 per-cycle read vs model");
            chk(64'(user_rd_ok), 64'(m_en), "R6 per-cycle access mask vs model");
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        tick();
        csr_we = 1'b1;
        csr_addr = a;
        csr_wdata = d;
        tick();
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        tick();
        csr_addr = a;
        @(negedge clk);
        chk(64'(csr_rdata), 64'(exp), req);
    endtask

    task automatic drive_evt(input logic [EW-1:0] v, input int n);
        tick();
        evt_i = v;
        repeat (n) @(posedge clk);
        #1;
        evt_i = '0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;

        // reset state
        for (int i = 0; i < N; i++) begin
            rd(12'h320 + 12'(i + 3), 32'h0, "R1 selector after reset");
            rd(12'hB00 + 12'(i + 3), 32'h0, "R1 low half after reset");
            rd(12'hB80 + 12'(i + 3), 32'h0, "R1 high half after reset");
        end
        rd(12'h306, 32'h0, "R1 access mask after reset");
        chk(64'(user_rd_ok), 64'h0, "R1 user_rd_ok after reset");

        // selectors
        wr(12'h323, 32'hFF);
        wr(12'h324, 32'h01);
        wr(12'h325, 32'h06);
        wr(12'h326, 32'h80);
        wr(12'h327, 32'h00);
        rd(12'h323, 32'hFD, "R5 bit 1 dropped on 0xFF write");
        rd(12'h325, 32'h04, "R5 bit 1 dropped on 0x06 write");
        rd(12'h324, 32'h01, "R4 selector 1 readback");
        rd(12'h326, 32'h80, "R4 selector 3 readback");

        // reserved event line alone
        drive_evt(8'h02, 5);
        rd(12'hB03, 32'd0, "R5 event line 1 does not count");
        rd(12'hB05, 32'd0, "R5 event line 1 does not count on ctr2");

        drive_evt(8'h01, 10);
        rd(12'hB03, 32'd10, "R3 single selected event");
        rd(12'hB04, 32'd10, "R3 ctr1 single event");
        rd(12'hB05, 32'd0, "R10 unselected ctr2 unchanged");
        rd(12'hB06, 32'd0, "R10 unselected ctr3 unchanged");

        drive_evt(8'h81, 6);
        rd(12'hB03, 32'd16, "R3 two selected events count once");
        rd(12'hB06, 32'd6, "R3 ctr3 event 7");

        drive_evt(8'hFF, 4);
        rd(12'hB03, 32'd20, "R3 all events ctr0");
        rd(12'hB05, 32'd4, "R3 all events ctr2");
        rd(12'hB06, 32'd10, "R3 all events ctr3");
        rd(12'hB07, 32'd0, "R3 empty selector never counts");

        // latency: pulse seen at edge E1, value changes at E3
        tick();
        csr_addr = 12'hB06;
        evt_i = 8'h80;
        tick();
        evt_i = '0;
        @(negedge clk);
        chk(64'(csr_rdata), 64'd10, "R2 no change after E1");
        @(negedge clk);
        chk(64'(csr_rdata), 64'd10, "R2 no change after E2");
        @(negedge clk);
        chk(64'(csr_rdata), 64'd11, "R2 change after E3");
        repeat (2) tick();

        // carry into high half
        wr(12'hB05, 32'hFFFF_FFFE);
        wr(12'hB85, 32'h7);
        drive_evt(8'h04, 3);
        rd(12'hB05, 32'h1, "R7 low half wrapped");
        rd(12'hB85, 32'h8, "R7 high half carried");

        // write priority over increment
        tick();
        csr_addr = 12'hB04;
        evt_i = 8'h01;
        repeat (3) tick();
        csr_we = 1'b1;
        csr_wdata = 32'h100;
        tick();
        csr_we = 1'b0;
        @(negedge clk);
        chk(64'(csr_rdata), 64'h100, "R8 low write wins over increment");
        @(negedge clk);
        chk(64'(csr_rdata), 64'h101, "R8 counting resumes");
        tick();
        csr_we = 1'b1;
        csr_addr = 12'hB84;
        csr_wdata = 32'h55;
        tick();
        csr_we = 1'b0;
        csr_addr = 12'hB04;
        @(negedge clk);
        chk(64'(csr_rdata), 64'h102, "R8 high write blocks increment of low half");
        tick();
        evt_i = '0;
        repeat (4) tick();
        rd(12'hB84, 32'h55, "R8 high half holds written value");

        // access mask
        wr(12'h306, 32'hFFFF_FFFF);
        rd(12'h306, 32'hF8, "R6 mask all ones");
        chk(64'(user_rd_ok), 64'h1F, "R6 user_rd_ok all ones");
        wr(12'h306, 32'h28);
        rd(12'h306, 32'h28, "R6 mask pattern");
        chk(64'(user_rd_ok), 64'h05, "R6 user_rd_ok pattern");

        // unimplemented indices
        wr(12'h328, 32'hFF);
        wr(12'hB08, 32'h123);
        rd(12'h328, 32'h0, "R9 selector index 5 reads zero");
        rd(12'hB08, 32'h0, "R9 counter index 5 reads zero");
        rd(12'hB01, 32'h0, "R9 low index below 3 reads zero");
        rd(12'h33F, 32'h0, "R9 top index reads zero");
        drive_evt(8'hFF, 2);
        rd(12'hB07, 32'h0, "R9 ignored writes leave ctr4 unchanged");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule